// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block watches eight asynchronous request pins. Each pin has its own 2-bit trigger field that selects what counts as a request: a low level, a high level, a rising edge or a falling edge. A detected condition sets a sticky cause flag for that pin. A per-pin enable decides whether the flag reaches the interrupt outputs. The pins are ORed in pairs onto four registered request lines.

Software uses a small register port to program the trigger fields and the enables, to read the flags, and to clear them. Writing a 0 to a flag bit clears that bit, and writing a 1 leaves it unchanged. A detection in the same cycle as a clear wins, so a level that is still present keeps its flag set. Every pin passes through a two-flop synchroniser before detection. Edges are found by comparing the synchronised value with its value one clock earlier, so reprogramming a trigger field cannot produce a false edge.

Top module: `ext_irq_detect`

## Requirements
- R1: While reset is high and in the cycle after it, all request lines are low. After reset the enable register (address 1) and the trigger register (address 2) read as zero.
- R2: Trigger code 00 sets the pin's flag on every clock while the synchronised pin is low.
- R3: Trigger code 01 sets the pin's flag on every clock while the synchronised pin is high.
- R4: Trigger code 10 sets the flag once on a low-to-high change. A high-to-low change or a steady high does not set it.
- R5: Trigger code 11 sets the flag once on a high-to-low change. A low-to-high change or a steady low does not set it.
- R6: A write to the flag register (address 0) clears every flag bit written as 0 and leaves bits written as 1 unchanged. Flag bit i belongs to pin i.
- R7: When a detection and a clear of the same flag fall in one cycle, the flag stays set.
- R8: A flag whose enable bit is 0 still sets, but it drives no request line.
- R9: Request line k is high when pin 2k or pin 2k+1 has both its flag and its enable set. The line is updated one clock after the flag.
- R10: Changing a pin's trigger field while the pin is steady does not set its flag in an edge mode.
- R11: Reads are registered. rd_data shows the register selected by rd_addr one clock later. Address 0 holds the flags (bits 7:0), address 1 the enables (bits 7:0), and address 2 the trigger fields (pin i in bits 2i+1:2i). Any other address reads zero.
- R12: A pin change sets the flag on the third rising clock edge after the change and raises the enabled request line on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 8 | Asynchronous external request pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Registered read data |
| irq_o | output | 4 | Registered request lines, one per pin pair |

## Verification
The hardest case to reach from the ports is a clear and a detection of the same flag landing in the same cycle. A level mode makes this case certain. The stimulus holds a pin at its active level, so a detection fires on every clock, and then issues the clear. A read one cycle later must still show the flag set. The stimulus for R10 switches the trigger fields of pins held high, first from level to edge and then between the two edge codes. It then confirms that no flag appears.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  localparam int unsigned REG_FLAGS  = 0;
  localparam int unsigned REG_ENABLE = 1;
  localparam int unsigned REG_TRIG   = 2;
endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/eid_detect.sv
module eid_detect
  import ext_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH-1:0]   level,
  input  logic [2*WIDTH-1:0] trig,
  output logic [WIDTH-1:0]   hit
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level;
  end

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      case (trig_e'(trig[2*i +: 2]))
        TRIG_LOW:  hit[i] = ~level[i];
        TRIG_HIGH: hit[i] =  level[i];
        TRIG_RISE: hit[i] =  level[i] & ~prev_q[i];
        default:   hit[i] = ~level[i] &  prev_q[i];
      endcase
    end
  end
endmodule

// File: rtl/eid_combine.sv
module eid_combine #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned GROUP = 2,
  localparam int unsigned LINES = WIDTH / GROUP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] flags,
  input  logic [WIDTH-1:0] en,
  output logic [LINES-1:0] irq
);
  logic [LINES-1:0] req_c;

  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign req_c[k] = |(flags[k*GROUP +: GROUP] & en[k*GROUP +: GROUP]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= req_c;
  end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS      = 8,
  parameter int unsigned PINS_PER_LINE = 2,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned ADDR_W        = 2,
  parameter int unsigned DATA_W        = 16,
  localparam int unsigned NUM_LINES    = NUM_PINS / PINS_PER_LINE,
  localparam int unsigned TRIG_W       = 2 * NUM_PINS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PINS-1:0]  pins_i,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic [NUM_LINES-1:0] irq_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_PINS;

  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] hit_vec;
  logic [NUM_PINS-1:0] flag_q;
  logic [NUM_PINS-1:0] en_q;
  logic [TRIG_W-1:0]   trig_q;
  logic                wr_flags, wr_en_reg, wr_trig;

  assign wr_flags  = wr_en && (wr_addr == ADDR_W'(REG_FLAGS));
  assign wr_en_reg = wr_en && (wr_addr == ADDR_W'(REG_ENABLE));
  assign wr_trig   = wr_en && (wr_addr == ADDR_W'(REG_TRIG));

  eid_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pins_i), .q(pin_sync)
  );

  eid_detect #(.WIDTH(NUM_PINS)) u_detect (
    .clk(clk), .rst(rst), .level(pin_sync), .trig(trig_q), .hit(hit_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      en_q   <= '0;
      trig_q <= '0;
    end else begin
      flag_q <= (wr_flags ? (flag_q & wr_data[NUM_PINS-1:0]) : flag_q) | hit_vec;
      if (wr_en_reg) en_q   <= wr_data[NUM_PINS-1:0];
      if (wr_trig)   trig_q <= wr_data[TRIG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        ADDR_W'(REG_FLAGS):  rd_data <= {{PAD_W{1'b0}}, flag_q};
        ADDR_W'(REG_ENABLE): rd_data <= {{PAD_W{1'b0}}, en_q};
        ADDR_W'(REG_TRIG):   rd_data <= DATA_W'(trig_q);
        default:             rd_data <= '0;
      endcase
    end
  end

  eid_combine #(.WIDTH(NUM_PINS), .GROUP(PINS_PER_LINE)) u_combine (
    .clk(clk), .rst(rst), .flags(flag_q), .en(en_q), .irq(irq_o)
  );
endmodule

// File: rtl/ext_irq_checker.sv
module ext_irq_checker
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 8,
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned ADDR_W    = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [NUM_PINS-1:0]  wr_flags,
  input logic [NUM_PINS-1:0]  hit_vec,
  input logic [NUM_PINS-1:0]  flag_q,
  input logic [NUM_PINS-1:0]  en_q,
  input logic [NUM_LINES-1:0] irq_o
);
  // R1: reset forces the request lines low
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (irq_o == '0));

  // R6: bits written 0 with no detection end up clear
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(REG_FLAGS)) |=>
      ((flag_q & ~$past(wr_flags) & ~$past(hit_vec)) == '0));

  // R7: any detection leaves its flag set next cycle
  a_r7_hit_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (hit_vec != '0) |=> ((flag_q & $past(hit_vec)) == $past(hit_vec)));

  // R8: with every enable off the lines go low
  a_r8_no_enable_no_req: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> (irq_o == '0));

  // R9: a raised line needs an enabled flag one cycle earlier
  a_r9_req_has_cause: assert property (@(posedge clk) disable iff (rst)
    (irq_o != '0) |-> ($past(flag_q & en_q) != '0));
endmodule

bind ext_irq_detect ext_irq_checker #(
  .NUM_PINS(NUM_PINS), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_flags(wr_data[NUM_PINS-1:0]), .hit_vec(hit_vec),
  .flag_q(flag_q), .en_q(en_q), .irq_o(irq_o)
);

// File: tb/sim_ext_irq_detect.sv
module sim_ext_irq_detect;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pins = 8'hFF;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [3:0]  irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_detect u0 (
    .clk(clk), .rst(rst), .pins_i(pins), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    cyc(1);
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    cyc(3);
    check("R1 irq in reset", {12'h0, irq}, 16'h0);
    check("R11 rd_data in reset", rd_data, 16'h0);
    rst = 1'b0;
    cyc(1);
    check("R1 irq after reset", {12'h0, irq}, 16'h0);
    rd(2'd1, v); check("R1 enables zero", v, 16'h0);
    rd(2'd2, v); check("R1 trigger zero", v, 16'h0);
    rd(2'd3, v); check("R11 unmapped reads zero", v, 16'h0);
    check("R8 flags set but disabled", {12'h0, irq}, 16'h0);
  endtask

  task automatic t_levels();
    logic [15:0] v;
    wr(2'd2, 16'hAAA4);
    rd(2'd2, v); check("R11 trigger readback", v, 16'hAAA4);
    cyc(2);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); check("R3 high level sets, R7 clear loses", v, 16'h0002);
    pins[0] = 1'b0; cyc(4);
    rd(2'd0, v); check("R2 low level sets", v, 16'h0003);
    pins[0] = 1'b1; cyc(3);
    wr(2'd0, 16'h00FE);
    rd(2'd0, v); check("R6 write one keeps bit", v, 16'h0002);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); check("R7 held level survives clear", v, 16'h0002);
    pins[1] = 1'b0; cyc(4);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); check("R6 clear after level gone", v, 16'h0000);
  endtask

  task automatic t_edges();
    logic [15:0] v;
    wr(2'd2, 16'hAAE4);
    cyc(2);
    rd(2'd0, v); check("R10 level to edge no flag", v, 16'h0000);
    pins[2] = 1'b0; cyc(4);
    rd(2'd0, v); check("R4 falling ignored in rise mode", v, 16'h0000);
    pins[2] = 1'b1; cyc(4);
    rd(2'd0, v); check("R4 rising sets", v, 16'h0004);
    pins[3] = 1'b0; cyc(4);
    rd(2'd0, v); check("R5 falling sets", v, 16'h000C);
    wr(2'd0, 16'h0000); cyc(2);
    rd(2'd0, v); check("R4 R5 steady no refire", v, 16'h0000);
    pins[3] = 1'b1; cyc(4);
    rd(2'd0, v); check("R5 rising ignored in fall mode", v, 16'h0000);
  endtask

  task automatic t_mode_switch();
    logic [15:0] v;
    wr(2'd2, 16'hA9E4); cyc(2);
    rd(2'd0, v); check("R3 pin4 high level", v, 16'h0010);
    wr(2'd2, 16'hAAE4);
    wr(2'd0, 16'h0000); cyc(3);
    rd(2'd0, v); check("R10 high level to rise no flag", v, 16'h0000);
    wr(2'd2, 16'hAEE4); cyc(3);
    rd(2'd0, v); check("R10 rise to fall no flag", v, 16'h0000);
  endtask

  task automatic t_enable();
    logic [15:0] v;
    pins[6] = 1'b0; cyc(3);
    pins[6] = 1'b1; cyc(4);
    rd(2'd0, v); check("R8 disabled pin still flags", v, 16'h0040);
    check("R8 no request while disabled", {12'h0, irq}, 16'h0);
    wr(2'd1, 16'h0080); cyc(1);
    check("R9 partner enable alone no request", {12'h0, irq}, 16'h0);
    wr(2'd1, 16'h0040); cyc(1);
    check("R9 pair 6/7 drives line 3", {12'h0, irq}, 16'h0008);
    rd(2'd1, v); check("R11 enable readback", v, 16'h0040);
    wr(2'd0, 16'h0000); cyc(1);
    check("R6 R9 clear drops line", {12'h0, irq}, 16'h0000);
  endtask

  task automatic t_latency();
    wr(2'd1, 16'h0001);
    pins[0] = 1'b0;
    cyc(3);
    check("R12 line low after three edges", {12'h0, irq}, 16'h0);
    cyc(1);
    check("R12 line high after four edges", {12'h0, irq}, 16'h0001);
    pins[0] = 1'b1; cyc(3);
    wr(2'd1, 16'h0002);
    wr(2'd0, 16'h0000); cyc(1);
    check("R9 line 0 low after clear", {12'h0, irq}, 16'h0);
    pins[1] = 1'b1; cyc(4);
    check("R9 pin1 drives line 0", {12'h0, irq}, 16'h0001);
  endtask

  initial begin
    t_reset();
    t_levels();
    t_edges();
    t_mode_switch();
    t_enable();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(10 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule